// File: doc/BRIEF.md
# Per-Line Programmable Edge Detector Bank

This block watches a bus of monitored input lines that may change at any time. Each line has a 2-bit edge mode that picks what counts as an event: a rising transition, a falling transition, either transition, or nothing. Each line also has a suppress bit. The inputs first pass through a two-stage synchroniser. The synchronised level is then compared against its value one cycle earlier, and any qualifying transition raises that line's bit in a registered event vector for exactly one clock.

The configuration sits in a bank of 32-bit words on a simple synchronous register port. Each word packs the mode fields of sixteen consecutive lines. A second set of words holds one suppress bit per line.

Software can program the modes in two ways. It can write whole words directly. It can also write a line number to an index register and then write a 2-bit value to a value register. In the second case the block rewrites only that line's field inside the right word, so several agents can set different lines without a read-modify-write race. The address range for all sixteen mode words is always reserved, and words past the implemented count read as zero and drop writes.

Top module: `edge_bank_top`

## Requirements
- R1: A level change on a line that is captured at clock edge k raises that line's bit of `evt_o` after edge k+2. The bit stays high for exactly one cycle, and no event is raised without a change of the synchronised level.
- R2: The 2-bit mode field selects the event kind: 00 detects a rising transition only, 01 a falling transition only, 10 both transitions, and 11 (reserved) disables the line.
- R3: The mode field of line n sits at bits [2*(n%16)+1 : 2*(n%16)] of mode word n/16, and mode word w has word address w (0x00 to 0x0F). Writing 0x00024000 to word 0 makes line 7 falling-edge and line 8 toggle, and reading word 0 back returns 0x00024000.
- R4: The suppress bit of line n is bit n%32 of the word at address 0x10 + n/32. While that bit is 1, line n raises no event.
- R5: Writing address 0x18 loads an 8-bit line index from bits [7:0]. A later write to address 0x19 replaces bits [1:0] into that line's mode field only, leaves the other fields of the word unchanged, and takes effect from the next clock edge. Reading 0x19 returns the indexed line's field, and reading 0x18 returns the index.
- R6: Mode words numbered ceil(NUM_LINES/16) and above are not implemented. Direct and indexed writes to them are accepted and have no effect, and they read as zero.
- R7: After reset all mode fields are 00, all suppress bits, the index and the read data are 0, and no event is raised.
- R8: Read data appears one cycle after the address is presented. Addresses above 0x19 read as zero.
- R9: Every line is evaluated independently in every cycle, so transitions on many lines at once raise all their qualifying events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_i | input | NUM_LINES | Monitored asynchronous lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| evt_o | output | NUM_LINES | One-cycle event per line |

## Verification
A corrupted mode or suppress bit stays hidden until its line next moves. It then shows at `evt_o` exactly three edges after the change, either as a missing event or as an extra one. A readback of the affected word exposes the same fault one cycle after the address is presented. A broken indexed merge shows up as changed neighbour fields in the word readback, and as events appearing or vanishing on those neighbour lines. The bench therefore compares every event cycle against a queued model and reads each touched word back.

// File: rtl/edb_pkg.sv
package edb_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;

  localparam int WORD_W          = 32;
  localparam int FIELD_W         = 2;
  localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
  localparam int CTRL_SLOTS      = 16;
  localparam int MASK_SLOTS      = 8;

  localparam logic [7:0] A_CTRL_BASE = 8'h00;
  localparam logic [7:0] A_MASK_BASE = 8'h10;
  localparam logic [7:0] A_INDEX     = 8'h18;
  localparam logic [7:0] A_VALUE     = 8'h19;

  // Bit offset of a field slot inside a mode word.
  function automatic logic [4:0] field_lsb(input logic [3:0] slot);
    return {slot, 1'b0};
  endfunction

  // Replace one 2-bit slot of a word, keep the rest.
  function automatic logic [WORD_W-1:0] merge_field(input logic [WORD_W-1:0] word,
                                                    input logic [3:0]        slot,
                                                    input logic [1:0]        val);
    logic [WORD_W-1:0] keep;
    logic [WORD_W-1:0] ins;
    keep = ~(32'h3 << field_lsb(slot));
    ins  = {30'b0, val} << field_lsb(slot);
    return (word & keep) | ins;
  endfunction

  function automatic logic [1:0] pick_field(input logic [WORD_W-1:0] word,
                                            input logic [3:0]        slot);
    return word[field_lsb(slot) +: 2];
  endfunction

  // Does a prev->cur transition qualify under the given mode?
  function automatic logic edge_hit(input edge_mode_e mode, input logic prev, input logic cur);
    case (mode)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/edb_sync.sv
module edb_sync #(
  parameter int WIDTH = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_o = stage2_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/edb_regbank.sv
module edb_regbank
  import edb_pkg::*;
#(
  parameter int NUM_LINES = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [7:0]             addr_i,
  input  logic [WORD_W-1:0]      wdata_i,
  output logic [WORD_W-1:0]      rdata_o,
  output logic [2*NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0]   mask_o,
  output logic                   ind_wr_o
);

  localparam int CTRL_IMPL = (NUM_LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int MASK_IMPL = (NUM_LINES + WORD_W - 1) / WORD_W;

  logic [7:0]        idx_q;
  logic [WORD_W-1:0] ctrl_rd [CTRL_SLOTS];
  logic [WORD_W-1:0] mask_rd [MASK_SLOTS];
  logic [WORD_W-1:0] rd_next;
  logic [WORD_W-1:0] rdata_q;
  logic              ind_wr;

  assign ind_wr   = we_i && (addr_i == A_VALUE);
  assign ind_wr_o = ind_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (we_i && addr_i == A_INDEX) idx_q <= wdata_i[7:0];
  end

  // Mode words: implemented slots hold flops, the rest read as zero.
  for (genvar gi = 0; gi < CTRL_SLOTS; gi++) begin : g_ctrl
    if (gi < CTRL_IMPL) begin : g_impl
      logic [WORD_W-1:0] word_q;
      logic              dir_hit;
      logic              ind_hit;
      assign dir_hit = we_i && (addr_i == A_CTRL_BASE + 8'(gi));
      assign ind_hit = ind_wr && (idx_q[7:4] == 4'(gi));
      always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (dir_hit) word_q <= wdata_i;
        else if (ind_hit) word_q <= merge_field(word_q, idx_q[3:0], wdata_i[1:0]);
      end
      assign ctrl_rd[gi] = word_q;
    end else begin : g_void
      assign ctrl_rd[gi] = '0;
    end
  end

  for (genvar gj = 0; gj < MASK_SLOTS; gj++) begin : g_mask
    if (gj < MASK_IMPL) begin : g_impl
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else if (we_i && addr_i == A_MASK_BASE + 8'(gj)) word_q <= wdata_i;
      end
      assign mask_rd[gj] = word_q;
    end else begin : g_void
      assign mask_rd[gj] = '0;
    end
  end

  // Line n's field lands at flat position 2n; its mask bit at n.
  for (genvar gn = 0; gn < NUM_LINES; gn++) begin : g_line
    assign mode_o[2*gn +: 2] = ctrl_rd[gn / FIELDS_PER_WORD][2*(gn % FIELDS_PER_WORD) +: 2];
    assign mask_o[gn]        = mask_rd[gn / WORD_W][gn % WORD_W];
  end

  always_comb begin
    rd_next = '0;
    if (addr_i[7:4] == 4'h0)                     rd_next = ctrl_rd[addr_i[3:0]];
    else if (addr_i[7:3] == A_MASK_BASE[7:3])    rd_next = mask_rd[addr_i[2:0]];
    else if (addr_i == A_INDEX)                  rd_next = {24'b0, idx_q};
    else if (addr_i == A_VALUE)                  rd_next = {30'b0, pick_field(ctrl_rd[idx_q[7:4]], idx_q[3:0])};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/edb_detect.sv
module edb_detect
  import edb_pkg::*;
#(
  parameter int NUM_LINES = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   cur_i,
  input  logic [NUM_LINES-1:0]   prev_i,
  input  logic [2*NUM_LINES-1:0] mode_i,
  input  logic [NUM_LINES-1:0]   mask_i,
  output logic [NUM_LINES-1:0]   hit_o,
  output logic [NUM_LINES-1:0]   evt_o
);

  logic [NUM_LINES-1:0] evt_q;

  for (genvar gn = 0; gn < NUM_LINES; gn++) begin : g_line
    assign hit_o[gn] = ~mask_i[gn] &
                       edge_hit(edge_mode_e'(mode_i[2*gn +: 2]), prev_i[gn], cur_i[gn]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= hit_o;
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/edge_bank_top.sv
module edge_bank_top #(
  parameter int NUM_LINES = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 reg_we_i,
  input  logic [7:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [NUM_LINES-1:0] evt_o
);

  logic [NUM_LINES-1:0]   line_sync;
  logic [NUM_LINES-1:0]   line_prev;
  logic [2*NUM_LINES-1:0] mode_flat;
  logic [NUM_LINES-1:0]   mask_flat;
  logic [NUM_LINES-1:0]   hit_vec;
  logic                   ind_wr;

  edb_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lines_i),
    .sync_o  (line_sync),
    .prev_o  (line_prev)
  );

  edb_regbank #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .mode_o   (mode_flat),
    .mask_o   (mask_flat),
    .ind_wr_o (ind_wr)
  );

  edb_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (line_sync),
    .prev_i (line_prev),
    .mode_i (mode_flat),
    .mask_i (mask_flat),
    .hit_o  (hit_vec),
    .evt_o  (evt_o)
  );

endmodule

// File: rtl/edge_bank_chk.sv
module edge_bank_chk #(
  parameter int NUM_LINES = 200
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_LINES-1:0]   evt,
  input logic [NUM_LINES-1:0]   line_sync,
  input logic [NUM_LINES-1:0]   line_prev,
  input logic [2*NUM_LINES-1:0] mode_flat,
  input logic [NUM_LINES-1:0]   mask_flat,
  input logic                   ind_wr,
  input logic [7:0]             reg_addr,
  input logic [31:0]            reg_rdata
);

  localparam int         CTRL_IMPL = (NUM_LINES + 15) / 16;
  localparam logic [7:0] IMPL_A    = 8'(CTRL_IMPL);

  logic [NUM_LINES-1:0] off_vec;

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++) off_vec[n] = (mode_flat[2*n +: 2] == 2'b11);
  end

  AST_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~($past(line_sync) ^ $past(line_prev))) == '0); // R1

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & $past(off_vec)) == '0); // R2

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & $past(mask_flat)) == '0); // R4

  AST_INDIRECT_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ind_wr |=> $countones(mode_flat ^ $past(mode_flat)) <= 2); // R5

  AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < 8'h10 && reg_addr >= IMPL_A) |=> reg_rdata == '0); // R6

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > 8'h19) |=> reg_rdata == '0); // R8

endmodule

bind edge_bank_top edge_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt       (evt_o),
  .line_sync (line_sync),
  .line_prev (line_prev),
  .mode_flat (mode_flat),
  .mask_flat (mask_flat),
  .ind_wr    (ind_wr),
  .reg_addr  (reg_addr_i),
  .reg_rdata (reg_rdata_o)
);

// File: tb/edge_bank_top_test.sv
module edge_bank_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 200;
  localparam int CTRL_IMPL  = (N + 15) / 16;
  localparam int MASK_IMPL  = (N + 31) / 32;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic          we = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  evt;

  typedef struct {
    int           due;
    logic [N-1:0] vec;
    string        tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        cur_e;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  logic [31:0] bword [16];
  logic [31:0] bmaskw [8];
  logic [7:0]  bidx;

  edge_bank_top #(.NUM_LINES(N)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lines_i     (lines),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .evt_o       (evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side view of one line's mode and mask, restated from the word layout.
  function automatic logic [1:0] line_mode(input int n);
    logic [31:0] w;
    w = bword[n >> 4];
    return {w[(n & 15) * 2 + 1], w[(n & 15) * 2]};
  endfunction

  function automatic logic line_masked(input int n);
    logic [31:0] w;
    w = bmaskw[n >> 5];
    return w[n & 31];
  endfunction

  // Monitor: compare events when a queued item falls due, otherwise expect silence.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      cur_e = sb.pop_front();
      checks++;
      if (evt !== cur_e.vec) begin
        errors++;
        $display("FAIL %s events at cycle %0d: got %h expected %h", cur_e.tag, cyc, evt, cur_e.vec);
      end
    end else if (rst_n && evt !== '0) begin
      checks++;
      errors++;
      $display("FAIL R1 spurious event at cycle %0d: got %h expected 0", cyc, evt);
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: got cycle %0d expected under %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Driver: apply a new line vector and queue the events it should cause.
  task automatic drive(input logic [N-1:0] nv, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    for (int n = 0; n < N; n++) begin
      logic o, c, h;
      o = lines[n];
      c = nv[n];
      case (line_mode(n))
        2'b00:   h = c && !o;
        2'b01:   h = !c && o;
        2'b10:   h = c != o;
        default: h = 1'b0;
      endcase
      e[n] = h && !line_masked(n);
    end
    lines = nv;
    sb.push_back('{due: cyc + 3, vec: e, tag: tag});
  endtask

  task automatic drive_random(input int count, input string tag);
    for (int k = 0; k < count; k++) begin
      logic [N-1:0] nv;
      for (int n = 0; n < N; n++) begin
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        nv[n] = rng[3];
      end
      drive(nv, tag);
    end
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1;
    addr = a;
    wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < 8'h10) begin
      if (int'(a) < CTRL_IMPL) bword[a[3:0]] = d;
    end else if (a < 8'h18) begin
      if (int'(a) - 16 < MASK_IMPL) bmaskw[a[2:0]] = d;
    end else if (a == 8'h18) begin
      bidx = d[7:0];
    end else if (a == 8'h19) begin
      if (int'(bidx[7:4]) < CTRL_IMPL) begin
        bword[bidx[7:4]][int'(bidx[3:0]) * 2]     = d[0];
        bword[bidx[7:4]][int'(bidx[3:0]) * 2 + 1] = d[1];
      end
    end
  endtask

  task automatic rd_check(input logic [7:0] a, input string tag);
    logic [31:0] expv;
    @(negedge clk);
    addr = a;
    @(negedge clk);
    if (a < 8'h10)       expv = bword[a[3:0]];
    else if (a < 8'h18)  expv = bmaskw[a[2:0]];
    else if (a == 8'h18) expv = {24'b0, bidx};
    else if (a == 8'h19) expv = {30'b0, line_mode(int'(bidx))};
    else                 expv = '0;
    checks++;
    if (rdata !== expv) begin
      errors++;
      $display("FAIL %s read addr %h: got %h expected %h", tag, a, rdata, expv);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bword[i] = '0;
    for (int i = 0; i < 8; i++)  bmaskw[i] = '0;
    bidx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (evt !== '0 || rdata !== '0) begin
      errors++;
      $display("FAIL R7 reset outputs: got evt %h rdata %h expected 0", evt, rdata);
    end
    rd_check(8'h00, "R7");
    rd_check(8'h10, "R7");
    rd_check(8'h18, "R7");

    // R2 default rising mode, plus whole-bus swings (R9)
    drive_random(20, "R2");
    drive('1, "R9");
    drive('0, "R9");
    drive('1, "R9");
    drain();

    // R3 packed field placement
    wr(8'h00, 32'h0002_4000);
    rd_check(8'h00, "R3");
    drive_random(20, "R3");
    drain();

    // R2 all four mode codes in one word, whole words of falling, toggle, reserved
    wr(8'h01, 32'hE4E4_E4E4);
    wr(8'h02, 32'hAAAA_AAAA);
    wr(8'h03, 32'h5555_5555);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_E4E4);
    drive_random(30, "R2");
    drain();

    // R4 suppress bits
    wr(8'h10, 32'h0000_FF00);
    wr(8'h16, 32'h0000_00FF);
    rd_check(8'h10, "R4");
    drive_random(20, "R4");
    drain();

    // R5 indexed merge: line 35 (word 2 slot 3) to rising
    wr(8'h18, 8'd35);
    wr(8'h19, 32'h0);
    rd_check(8'h02, "R5");
    rd_check(8'h18, "R5");
    rd_check(8'h19, "R5");
    // highest line 199 set to falling and unsuppressed
    wr(8'h18, 8'd199);
    wr(8'h19, 32'h1);
    wr(8'h16, 32'h0);
    rd_check(8'h0C, "R5");
    begin
      logic [N-1:0] v;
      v = lines;
      v[N-1] = 1'b1;
      drive(v, "R5");
      v[N-1] = 1'b0;
      drive(v, "R5");
    end
    drive_random(20, "R5");
    drain();

    // R6 unimplemented words
    wr(8'h0D, 32'hFFFF_FFFF);
    rd_check(8'h0D, "R6");
    rd_check(8'h0F, "R6");
    wr(8'h18, 8'hE5);
    wr(8'h19, 32'h2);
    rd_check(8'h19, "R6");
    rd_check(8'h0C, "R6");
    drive_random(10, "R6");
    drain();

    // R8 unmapped addresses
    rd_check(8'h40, "R8");
    rd_check(8'h1A, "R8");

    drain();
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 pending events: got %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule